// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps the time of day and the calendar date as packed BCD fields: seconds, minutes, hours, day of week, date, month and a two-digit year. A free-running reference enable at 32768 Hz is divided internally to one step per second. Each step ripples through a cascade of counters with unequal radices: 60, 60, 24 (or 12 with an AM/PM flag), the length of the current month, 12 and 100. Month lengths and leap years are derived from the current month and year, so software never has to correct the date.

Any field can be written through a synchronous load port: one field per clock, chosen by a select code. Every field is always visible on its own parallel output. Writing the seconds field also restarts the second divider, so the first step after the write comes one full second later. Writing the hours field also sets the hour mode.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, the outputs read sec_o 0x00, min_o 0x00, hour_o 0x00 (24-hour mode), dow_o 1, date_o 0x01, month_o 0x01 and year_o 0x00.
- R2: The seconds field advances by exactly one for every DIV_RATIO clock cycles in which ref_tick is high. With ref_tick low and no load, no field changes.
- R3: Seconds and minutes count BCD 00 to 59. Going from 59 to 00 carries one step into the next field in the same clock.
- R4: In 24-hour mode, hour_o[5:0] counts BCD 00 to 23 and hour_o[7:6] read 0. The step from 23 to 00 advances the day (date and day of week).
- R5: In 12-hour mode, hour_o[6] is 1, hour_o[5] is the PM flag and hour_o[4:0] holds hour 01 to 12 in BCD. Hours run 12, 01, ..., 11. PM toggles only on the step from 11 to 12. The step from 11 PM to 12 AM (midnight) advances the day.
- R6: The date counts from 01 up to the length of the current month: 30 for months 04, 06, 09 and 11, 28 for month 02 in a common year, and 31 otherwise. It then returns to 01 and advances the month.
- R7: A year whose two-digit value is divisible by 4 (00 included, meaning 2000) is a leap year, and month 02 then has a day 29.
- R8: Month 12 wraps to 01 and advances the BCD year. Year 99 wraps to 00.
- R9: Day of week counts 1 to 7 and wraps from 7 to 1 at every day advance, independent of the date.
- R10: When ld_en is high, ld_sel picks the field: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. ld_data is written there, and the new value shows on the output one clock later. Other fields are untouched, and no counting happens in a load cycle. For hours, ld_data[6] selects 12-hour mode. In that mode ld_data[5] is PM and ld_data[4:0] the hour. In 24-hour mode ld_data[5:0] is the hour.
- R11: Loading the seconds field clears the divider, so the next seconds step occurs after DIV_RATIO further ref_tick cycles.
- R12: A date loaded beyond the current month's length is replaced by 01 at the next day advance, and the month advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable at the 32768 Hz reference rate |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 3 | Field select for a load |
| ld_data | input | 8 | BCD value to load |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours with mode and PM bits |
| dow_o | output | 3 | Day of week 1..7 |
| date_o | output | 8 | Date of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |

## Verification
The assertions check the following on every clock: seconds wrap from 59 to 00, minutes hold unless seconds wrap, the PM flag holds except at 11, the date moves only by one BCD step or back to 01, the day of week stays within 1..7, and a seconds load lands on the next cycle. Only the bench's scenarios can show that the cascade ends in the right values. These cover the month-length table, the leap-year rule across several years, year 99 wrapping, midnight in 12-hour mode, and the divider restarting after a seconds write, all of which depend on long chains of carries.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DOW   = 3'd3,
    FLD_DATE  = 3'd4,
    FLD_MONTH = 3'd5,
    FLD_YEAR  = 3'd6,
    FLD_NONE  = 3'd7
  } field_sel_e;

  // Two-digit BCD increment; wrapping is decided by the caller.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'h0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // (10*tens + units) mod 4 == (2*tens + units) mod 4
  function automatic logic is_leap(input logic [7:0] yr);
    logic [1:0] r;
    r = {yr[4], 1'b0} + yr[1:0];
    return (r == 2'b00);
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic leap);
    logic [7:0] d;
    case (mon)
      8'h02:                      d = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
      default:                    d = 8'h31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int DIV_RATIO = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_en,
  input  logic clr,
  output logic sec_step
);
  localparam int CNT_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (ref_en) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  assign sec_step = ref_en && !clr && (cnt == LAST);
endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
  import cal_pkg::*;
#(
  parameter logic [7:0] MIN_VAL = 8'h00,
  parameter logic [7:0] RST_VAL = 8'h00,
  parameter logic [7:0] MASK    = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic [7:0] max_val,
  input  logic       ld,
  input  logic [7:0] ld_val,
  output logic [7:0] value,
  output logic       wrap
);
  logic at_top;
  assign at_top = (value >= max_val);
  assign wrap   = step && at_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= RST_VAL;
    end else if (ld) begin
      value <= ld_val & MASK;
    end else if (step) begin
      value <= at_top ? MIN_VAL : bcd_inc(value);
    end
  end
endmodule

// File: rtl/cal_hour_unit.sv
module cal_hour_unit
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       ld,
  input  logic [7:0] ld_val,
  output logic [7:0] hour_o,
  output logic       day_carry
);
  logic [5:0] hr;
  logic       pm;
  logic       mode12;
  logic [7:0] hr_next;

  assign hr_next = bcd_inc({2'b00, hr});

  always_ff @(posedge clk) begin
    if (rst) begin
      hr     <= 6'h00;
      pm     <= 1'b0;
      mode12 <= 1'b0;
    end else if (ld) begin
      mode12 <= ld_val[6];
      if (ld_val[6]) begin
        pm <= ld_val[5];
        hr <= {1'b0, ld_val[4:0]};
      end else begin
        pm <= 1'b0;
        hr <= ld_val[5:0];
      end
    end else if (step) begin
      if (!mode12) begin
        hr <= (hr >= 6'h23) ? 6'h00 : hr_next[5:0];
      end else if (hr == 6'h11) begin
        hr <= 6'h12;
        pm <= ~pm;
      end else if (hr >= 6'h12) begin
        hr <= 6'h01;
      end else begin
        hr <= hr_next[5:0];
      end
    end
  end

  assign day_carry = step && (mode12 ? (hr == 6'h11 && pm) : (hr >= 6'h23));
  assign hour_o    = mode12 ? {2'b01, pm, hr[4:0]} : {2'b00, hr};
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int DIV_RATIO = 32768
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_tick,
  input  logic       ld_en,
  input  logic [2:0] ld_sel,
  input  logic [7:0] ld_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [2:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);
  field_sel_e sel;
  logic       run;
  logic       sec_step;
  logic       sec_wrap, min_wrap, day_step, date_wrap, month_wrap, year_wrap;
  logic [7:0] date_max;

  assign sel = ld_en ? field_sel_e'(ld_sel) : FLD_NONE;
  assign run = !ld_en;

  cal_prescaler #(.DIV_RATIO(DIV_RATIO)) u_presc (
    .clk(clk), .rst(rst), .ref_en(ref_tick),
    .clr(sel == FLD_SEC), .sec_step(sec_step)
  );

  cal_bcd_field #(.MIN_VAL(8'h00), .RST_VAL(8'h00), .MASK(8'h7F)) u_sec (
    .clk(clk), .rst(rst), .step(sec_step && run), .max_val(8'h59),
    .ld(sel == FLD_SEC), .ld_val(ld_data), .value(sec_o), .wrap(sec_wrap)
  );

  cal_bcd_field #(.MIN_VAL(8'h00), .RST_VAL(8'h00), .MASK(8'h7F)) u_min (
    .clk(clk), .rst(rst), .step(sec_wrap), .max_val(8'h59),
    .ld(sel == FLD_MIN), .ld_val(ld_data), .value(min_o), .wrap(min_wrap)
  );

  cal_hour_unit u_hour (
    .clk(clk), .rst(rst), .step(min_wrap),
    .ld(sel == FLD_HOUR), .ld_val(ld_data),
    .hour_o(hour_o), .day_carry(day_step)
  );

  // Day of week: independent 1..7 ring advanced at each day boundary.
  always_ff @(posedge clk) begin
    if (rst) begin
      dow_o <= 3'd1;
    end else if (sel == FLD_DOW) begin
      dow_o <= ld_data[2:0];
    end else if (day_step) begin
      dow_o <= (dow_o >= 3'd7) ? 3'd1 : dow_o + 3'd1;
    end
  end

  assign date_max = month_days(month_o, is_leap(year_o));

  cal_bcd_field #(.MIN_VAL(8'h01), .RST_VAL(8'h01), .MASK(8'h3F)) u_date (
    .clk(clk), .rst(rst), .step(day_step), .max_val(date_max),
    .ld(sel == FLD_DATE), .ld_val(ld_data), .value(date_o), .wrap(date_wrap)
  );

  cal_bcd_field #(.MIN_VAL(8'h01), .RST_VAL(8'h01), .MASK(8'h1F)) u_month (
    .clk(clk), .rst(rst), .step(date_wrap), .max_val(8'h12),
    .ld(sel == FLD_MONTH), .ld_val(ld_data), .value(month_o), .wrap(month_wrap)
  );

  cal_bcd_field #(.MIN_VAL(8'h00), .RST_VAL(8'h00), .MASK(8'hFF)) u_year (
    .clk(clk), .rst(rst), .step(month_wrap), .max_val(8'h99),
    .ld(sel == FLD_YEAR), .ld_val(ld_data), .value(year_o), .wrap(year_wrap)
  );

  logic unused_ok;
  assign unused_ok = year_wrap;
endmodule

// File: rtl/cal_checker.sv
module cal_checker
  import cal_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       ld_en,
  input logic [2:0] ld_sel,
  input logic [7:0] ld_data,
  input logic       sec_step,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [2:0] dow_o,
  input logic [7:0] date_o
);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && !sec_step) |=> $stable(sec_o));

  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && sec_step && sec_o == 8'h59) |=> (sec_o == 8'h00));

  assert_min_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && !(sec_step && sec_o == 8'h59)) |=> $stable(min_o));

  assert_pm_only_at_eleven_R5: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && hour_o[6] && hour_o[4:0] != 5'h11) |=> $stable(hour_o[6:5]));

  assert_date_step_R6: assert property (@(posedge clk) disable iff (rst)
    (!ld_en) |=> (date_o == $past(date_o) || date_o == 8'h01 ||
                  date_o == bcd_inc($past(date_o))));

  assert_dow_range_R9: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && dow_o >= 3'd1 && dow_o <= 3'd7) |=> (dow_o >= 3'd1 && dow_o <= 3'd7));

  assert_sec_load_R10: assert property (@(posedge clk) disable iff (rst)
    (ld_en && ld_sel == 3'd0) |=> (sec_o == ($past(ld_data) & 8'h7F)));
endmodule

bind bcd_calendar cal_checker u_cal_chk (
  .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
  .sec_step(sec_step), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
  .dow_o(dow_o), .date_o(date_o)
);

// File: tb/tb_bcd_calendar.sv
module tb_bcd_calendar;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_tick = 1'b0;
  logic       ld_en = 1'b0;
  logic [2:0] ld_sel = 3'd0;
  logic [7:0] ld_data = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, date_o, month_o, year_o;
  logic [2:0] dow_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  bcd_calendar #(.DIV_RATIO(DIV)) dut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_data(ld_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .dow_o(dow_o), .date_o(date_o), .month_o(month_o), .year_o(year_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = s; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic advance(input int secs);
    @(negedge clk);
    ref_tick = 1'b1;
    repeat (secs * DIV) @(negedge clk);
    ref_tick = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    load(3'd2, h); load(3'd1, m); load(3'd0, s);
  endtask

  task automatic set_date(input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
    load(3'd4, d); load(3'd5, mo); load(3'd6, y);
  endtask

  task automatic roll_day();
    set_time(8'h23, 8'h59, 8'h59);
    advance(1);
  endtask

  task automatic t_reset();
    check("R1 sec", sec_o, 8'h00);
    check("R1 min", min_o, 8'h00);
    check("R1 hour", hour_o, 8'h00);
    check("R1 dow", {5'd0, dow_o}, 8'd1);
    check("R1 date", date_o, 8'h01);
    check("R1 month", month_o, 8'h01);
    check("R1 year", year_o, 8'h00);
  endtask

  task automatic t_prescaler();
    repeat (10) @(negedge clk);
    check("R2 idle no change", sec_o, 8'h00);
    advance(1);
    check("R2 one second", sec_o, 8'h01);
    @(negedge clk); ref_tick = 1'b1;
    repeat (DIV - 1) @(negedge clk);
    ref_tick = 1'b0;
    check("R2 partial second", sec_o, 8'h01);
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
    check("R2 full count", sec_o, 8'h02);
    // Divider now mid-count; a seconds write restarts it.
    @(negedge clk); ref_tick = 1'b1;
    repeat (2) @(negedge clk);
    ref_tick = 1'b0;
    load(3'd0, 8'h30);
    check("R11 loaded sec", sec_o, 8'h30);
    @(negedge clk); ref_tick = 1'b1;
    repeat (DIV - 1) @(negedge clk);
    ref_tick = 1'b0;
    check("R11 no early step", sec_o, 8'h30);
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
    check("R11 step after full period", sec_o, 8'h31);
  endtask

  task automatic t_sec_min();
    set_time(8'h05, 8'h59, 8'h58);
    advance(1);
    check("R3 sec 59", sec_o, 8'h59);
    check("R3 min held", min_o, 8'h59);
    advance(1);
    check("R3 sec wrap", sec_o, 8'h00);
    check("R3 min wrap", min_o, 8'h00);
    check("R3 hour carry", hour_o, 8'h06);
    set_time(8'h07, 8'h09, 8'h59);
    advance(1);
    check("R3 min digit carry", min_o, 8'h10);
  endtask

  task automatic t_24h();
    load(3'd3, 8'd7);
    set_date(8'h10, 8'h05, 8'h23);
    roll_day();
    check("R4 hour 23 to 00", hour_o, 8'h00);
    check("R4 date advance", date_o, 8'h11);
    check("R9 dow 7 to 1", {5'd0, dow_o}, 8'd1);
    set_time(8'h09, 8'h59, 8'h59);
    advance(1);
    check("R4 hour 09 to 10", hour_o, 8'h10);
  endtask

  task automatic t_12h();
    load(3'd3, 8'd3);
    set_date(8'h15, 8'h05, 8'h23);
    set_time(8'h51, 8'h59, 8'h59);
    advance(1);
    check("R5 11AM to 12PM", hour_o, 8'h72);
    check("R5 no day at noon", date_o, 8'h15);
    set_time(8'h72, 8'h59, 8'h59);
    advance(1);
    check("R5 12PM to 1PM", hour_o, 8'h61);
    set_time(8'h71, 8'h59, 8'h59);
    advance(1);
    check("R5 11PM to 12AM", hour_o, 8'h52);
    check("R5 midnight date", date_o, 8'h16);
    check("R9 dow 3 to 4", {5'd0, dow_o}, 8'd4);
    set_time(8'h52, 8'h59, 8'h59);
    advance(1);
    check("R5 12AM to 1AM", hour_o, 8'h41);
  endtask

  task automatic t_month_len();
    set_date(8'h30, 8'h04, 8'h23);
    roll_day();
    check("R6 Apr30 date", date_o, 8'h01);
    check("R6 Apr30 month", month_o, 8'h05);
    set_date(8'h30, 8'h01, 8'h23);
    roll_day();
    check("R6 Jan30 to 31", date_o, 8'h31);
    roll_day();
    check("R6 Jan31 month", month_o, 8'h02);
    set_date(8'h28, 8'h02, 8'h23);
    roll_day();
    check("R6 Feb28 common", month_o, 8'h03);
    check("R6 Feb28 date", date_o, 8'h01);
  endtask

  task automatic t_leap();
    set_date(8'h28, 8'h02, 8'h24);
    roll_day();
    check("R7 2024 Feb29", date_o, 8'h29);
    roll_day();
    check("R7 2024 Mar1", month_o, 8'h03);
    set_date(8'h28, 8'h02, 8'h00);
    roll_day();
    check("R7 2000 Feb29", date_o, 8'h29);
    set_date(8'h28, 8'h02, 8'h12);
    roll_day();
    check("R7 2012 Feb29", date_o, 8'h29);
    set_date(8'h28, 8'h02, 8'h10);
    roll_day();
    check("R7 2010 no Feb29", date_o, 8'h01);
  endtask

  task automatic t_year();
    set_date(8'h31, 8'h12, 8'h45);
    roll_day();
    check("R8 Dec to Jan", month_o, 8'h01);
    check("R8 year 45 to 46", year_o, 8'h46);
    set_date(8'h31, 8'h12, 8'h99);
    roll_day();
    check("R8 year 99 to 00", year_o, 8'h00);
    check("R8 new-year date", date_o, 8'h01);
  endtask

  task automatic t_load();
    set_date(8'h17, 8'h08, 8'h30);
    load(3'd6, 8'h77);
    check("R10 year loaded", year_o, 8'h77);
    check("R10 month untouched", month_o, 8'h08);
    check("R10 date untouched", date_o, 8'h17);
    load(3'd3, 8'd5);
    check("R10 dow loaded", {5'd0, dow_o}, 8'd5);
    set_date(8'h30, 8'h02, 8'h23);
    roll_day();
    check("R12 overlong date", date_o, 8'h01);
    check("R12 month advance", month_o, 8'h03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_prescaler();
    t_sec_min();
    t_24h();
    t_12h();
    t_month_len();
    t_leap();
    t_year();
    t_load();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule